// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block is an always-on controller that takes one switchable logic domain down to OFF and back up to ON. A level request input selects the wanted state. The controller then runs a fixed ordering. Going down, it clamps the outputs first, then takes a retention snapshot, and only then removes the supply. Coming up, it restores the supply first, then writes the snapshot back into the domain registers, and only after that releases the clamps. Each step lasts one clock cycle. The save and restore strobes are single-cycle pulses.

A small model of the gated domain sits next to the controller so that the ordering can be observed from the ports. It holds a bank of working registers with a write port and a read port, and a matching retention bank. While the supply is off, the working registers lose their contents, which the model represents as all ones. The read data crosses to the always-on side through a registered clamp. That clamp forces the data to zero whenever isolation is active.

Top module: `pwr_domain_seq`

## Requirements
- R1: After a synchronous reset the status is ON (2'b01), isolation is 0, the supply switch is 1, both strobes are 0, and every domain register reads 0.
- R2: Power-down order. Suppose `pwr_req` is low at a clock edge while the status is ON. After that edge isolation is 1 and the status is 2'b10. One edge later `ret_save` is 1 for exactly one cycle. One edge after that the switch is 0 and the status is OFF (2'b00).
- R3: Power-up order. Suppose `pwr_req` is high at an edge while the status is OFF. After that edge the switch is 1 and the status is 2'b11. One edge later `ret_restore` is 1 for exactly one cycle. One edge after that isolation is still 1. One edge after that isolation is 0 and the status is ON.
- R4: Every change of the supply switch happens with isolation already at 1 in the cycle before the change and in the cycle after it.
- R5: Read data is registered: `dom_rdata` after an edge equals register `dom_raddr` if isolation was 0 at that edge, and equals 0 otherwise.
- R6: Data written while ON reads back unchanged after a full power-down/power-up cycle, for every register index.
- R7: Writes have no effect unless the status is ON. Writes attempted while OFF or during a transition leave the register contents unchanged.
- R8: The request is sampled only in the ON and OFF states. A request that reverses during a sequence lets that sequence finish to its stable state first, and then starts the opposite sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | 1 requests ON, 0 requests OFF |
| dom_we | input | 1 | Domain register write enable |
| dom_waddr | input | AW | Domain register write index |
| dom_wdata | input | W | Domain register write data |
| dom_raddr | input | AW | Domain register read index |
| dom_rdata | output | W | Clamped, registered read data |
| iso_en | output | 1 | Isolation enable |
| ret_save | output | 1 | Retention save strobe |
| ret_restore | output | 1 | Retention restore strobe |
| sw_on | output | 1 | Supply switch control, 1 = supplied |
| pwr_status | output | 2 | 00 OFF, 01 ON, 10 going down, 11 going up |

## Verification
The hardest situation to reach is a request that reverses in the middle of a sequence. The controller must ignore the reversal until it settles, and must then start the opposite sequence at once. The bench lowers the request and raises it again one cycle later, while the save step is pending. It then checks every status code cycle by cycle through OFF and back to ON. Retention is checked with a different data pattern per power cycle and per register. Writes are attempted while OFF and in the middle of a sequence, so that a lost, skipped or misplaced save or restore appears as a wrong read-back.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [2:0] {
    ST_ON, ST_ISO, ST_SAVE, ST_OFF, ST_UP, ST_RESTORE, ST_REL
  } seq_state_t;

  localparam logic [1:0] STAT_OFF  = 2'b00;
  localparam logic [1:0] STAT_ON   = 2'b01;
  localparam logic [1:0] STAT_DOWN = 2'b10;
  localparam logic [1:0] STAT_UP   = 2'b11;

  typedef struct packed {
    logic       iso;
    logic       save;
    logic       restore;
    logic       sw;
    logic [1:0] status;
  } seq_out_t;

  function automatic seq_out_t decode_state(seq_state_t s);
    seq_out_t o;
    o = '{iso: 1'b1, save: 1'b0, restore: 1'b0, sw: 1'b1, status: STAT_UP};
    case (s)
      ST_ON:      begin o.iso = 1'b0; o.status = STAT_ON; end
      ST_ISO:     o.status = STAT_DOWN;
      ST_SAVE:    begin o.save = 1'b1; o.status = STAT_DOWN; end
      ST_OFF:     begin o.sw = 1'b0; o.status = STAT_OFF; end
      ST_UP:      o.status = STAT_UP;
      ST_RESTORE: o.restore = 1'b1;
      ST_REL:     o.status = STAT_UP;
      default:    o.status = STAT_UP;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_req,
  output logic       iso_en,
  output logic       ret_save,
  output logic       ret_restore,
  output logic       sw_on,
  output logic [1:0] pwr_status
);

  seq_state_t state, state_nxt;
  seq_out_t   outs;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_ON:      if (!pwr_req) state_nxt = ST_ISO;
      ST_ISO:     state_nxt = ST_SAVE;
      ST_SAVE:    state_nxt = ST_OFF;
      ST_OFF:     if (pwr_req) state_nxt = ST_UP;
      ST_UP:      state_nxt = ST_RESTORE;
      ST_RESTORE: state_nxt = ST_REL;
      ST_REL:     state_nxt = ST_ON;
      default:    state_nxt = ST_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ON;
      outs  <= decode_state(ST_ON);
    end else begin
      state <= state_nxt;
      outs  <= decode_state(state_nxt);
    end
  end

  assign iso_en      = outs.iso;
  assign ret_save    = outs.save;
  assign ret_restore = outs.restore;
  assign sw_on       = outs.sw;
  assign pwr_status  = outs.status;

  // R2: save only while isolated and supplied
  assert_save_isolated_R2: assert property (@(posedge clk) disable iff (rst)
    ret_save |-> (iso_en && sw_on));

  // R2: supply falls only right after a save pulse
  assert_off_after_save_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_on) |-> $past(ret_save));

  // R3: restore only once supply has been back for a cycle
  assert_restore_supplied_R3: assert property (@(posedge clk) disable iff (rst)
    ret_restore |-> (sw_on && $past(sw_on) && iso_en));

  // R3: isolation released two cycles after the restore pulse
  assert_release_after_restore_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_en) |-> $past(ret_restore, 2));

  // R4: any switch change is bracketed by isolation
  assert_switch_isolated_R4: assert property (@(posedge clk) disable iff (rst)
    (sw_on != $past(sw_on)) |-> (iso_en && $past(iso_en)));

  // R2/R3: strobes never overlap and each lasts one cycle
  assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(ret_save && ret_restore));
  assert_save_single_R2: assert property (@(posedge clk) disable iff (rst)
    ret_save |=> !ret_save);

endmodule

// File: rtl/pds_domain.sv
module pds_domain #(
  parameter int NREG = 4,
  parameter int W    = 8,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_on,
  input  logic          ret_save,
  input  logic          ret_restore,
  input  logic          wr_ok,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rword
);

  logic [W-1:0] work [NREG];
  logic [W-1:0] keep [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        work[i] <= '0;
        keep[i] <= '0;
      end else begin
        if (ret_save) keep[i] <= work[i];
        if (!sw_on)
          work[i] <= '1;
        else if (ret_restore)
          work[i] <= keep[i];
        else if (we && wr_ok && (waddr == AW'(i)))
          work[i] <= wdata;
      end
    end
  end

  always_comb begin
    rword = '0;
    if (int'(raddr) < NREG) rword = work[raddr];
  end

  // R7: a refused write leaves the addressed register alone
  assert_refused_write_R7: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_ok && sw_on && !ret_restore) |=> (work[$past(waddr)] == $past(work[waddr])));

endmodule

// File: rtl/pds_iso_clamp.sv
module pds_iso_clamp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         iso_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (iso_en) dout <= '0;
    else             dout <= din;
  end

  // R5: clamped data is zero after any isolated edge
  assert_clamp_zero_R5: assert property (@(posedge clk) disable iff (rst)
    iso_en |=> (dout == '0));

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int NREG = 4,
  parameter int W    = 8,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_req,
  input  logic          dom_we,
  input  logic [AW-1:0] dom_waddr,
  input  logic [W-1:0]  dom_wdata,
  input  logic [AW-1:0] dom_raddr,
  output logic [W-1:0]  dom_rdata,
  output logic          iso_en,
  output logic          ret_save,
  output logic          ret_restore,
  output logic          sw_on,
  output logic [1:0]    pwr_status
);

  logic [W-1:0] rword;
  logic         wr_ok;

  pds_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .pwr_req     (pwr_req),
    .iso_en      (iso_en),
    .ret_save    (ret_save),
    .ret_restore (ret_restore),
    .sw_on       (sw_on),
    .pwr_status  (pwr_status)
  );

  assign wr_ok = (pwr_status == pds_pkg::STAT_ON);

  pds_domain #(.NREG(NREG), .W(W)) u_dom (
    .clk         (clk),
    .rst         (rst),
    .sw_on       (sw_on),
    .ret_save    (ret_save),
    .ret_restore (ret_restore),
    .wr_ok       (wr_ok),
    .we          (dom_we),
    .waddr       (dom_waddr),
    .wdata       (dom_wdata),
    .raddr       (dom_raddr),
    .rword       (rword)
  );

  pds_iso_clamp #(.W(W)) u_clamp (
    .clk    (clk),
    .rst    (rst),
    .iso_en (iso_en),
    .din    (rword),
    .dout   (dom_rdata)
  );

  // R1: ON status implies unclamped, supplied, no strobes
  assert_on_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (pwr_status == pds_pkg::STAT_ON) |-> (!iso_en && sw_on && !ret_save && !ret_restore));

  // R8: from ON, the only exit is the down sequence
  assert_leave_on_down_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_status) == pds_pkg::STAT_ON && pwr_status != pds_pkg::STAT_ON)
      |-> (pwr_status == pds_pkg::STAT_DOWN));

endmodule

// File: tb/test_pwr_domain_seq.sv
module test_pwr_domain_seq;

  localparam int NREG = 4;
  localparam int W    = 8;
  localparam int AW   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwr_req = 1'b1;
  logic          dom_we = 1'b0;
  logic [AW-1:0] dom_waddr = '0;
  logic [W-1:0]  dom_wdata = '0;
  logic [AW-1:0] dom_raddr = '0;
  logic [W-1:0]  dom_rdata;
  logic          iso_en, ret_save, ret_restore, sw_on;
  logic [1:0]    pwr_status;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model [NREG];

  always #5 clk = ~clk;

  pwr_domain_seq #(.NREG(NREG), .W(W)) i_pwr_domain_seq (
    .clk(clk), .rst(rst), .pwr_req(pwr_req),
    .dom_we(dom_we), .dom_waddr(dom_waddr), .dom_wdata(dom_wdata),
    .dom_raddr(dom_raddr), .dom_rdata(dom_rdata),
    .iso_en(iso_en), .ret_save(ret_save), .ret_restore(ret_restore),
    .sw_on(sw_on), .pwr_status(pwr_status)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {iso, save, restore, sw, status}
  task automatic chk_ctl(string req, logic [5:0] exp);
    chk(req, {26'd0, iso_en, ret_save, ret_restore, sw_on, pwr_status}, {26'd0, exp});
  endtask

  function automatic logic [W-1:0] pat(int cyc, int idx);
    return W'((idx * 37 + cyc * 11 + 5) & 8'hff);
  endfunction

  task automatic read_chk(string req, int idx, logic [W-1:0] exp);
    dom_raddr = AW'(idx);
    step();
    chk(req, {24'd0, dom_rdata}, {24'd0, exp});
  endtask

  task automatic write_reg(int idx, logic [W-1:0] d);
    dom_we = 1'b1; dom_waddr = AW'(idx); dom_wdata = d;
    step();
    dom_we = 1'b0;
  endtask

  task automatic go_down(string req);
    pwr_req = 1'b0;
    step(); chk_ctl(req, 6'b1001_10);
    step(); chk_ctl(req, 6'b1101_10);
    step(); chk_ctl(req, 6'b1000_00);
  endtask

  task automatic go_up(string req);
    pwr_req = 1'b1;
    step(); chk_ctl(req, 6'b1001_11);
    step(); chk_ctl(req, 6'b1011_11);
    step(); chk_ctl(req, 6'b1001_11);
    step(); chk_ctl(req, 6'b0001_01);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 1'b0;
    // R1: reset state
    chk_ctl("R1", 6'b0001_01);
    for (int i = 0; i < NREG; i++) begin
      model[i] = '0;
      read_chk("R1", i, '0);
    end

    for (int cyc = 0; cyc < 6; cyc++) begin
      for (int i = 0; i < NREG; i++) begin
        model[i] = pat(cyc, i);
        write_reg(i, model[i]);
      end
      // R5: unclamped read while ON
      read_chk("R5", cyc % NREG, model[cyc % NREG]);
      go_down("R2");
      // R4: switch changed only inside isolation (checked by go_down order)
      chk("R4", {31'd0, iso_en}, 32'd1);
      // R5: clamp while OFF
      read_chk("R5", cyc % NREG, '0);
      // R7: write while OFF is refused
      write_reg(cyc % NREG, ~model[cyc % NREG]);
      go_up("R3");
      step();
      for (int i = 0; i < NREG; i++) read_chk("R6", i, model[i]);
    end

    // R7: write during a transition is refused
    pwr_req = 1'b0;
    step(); chk_ctl("R2", 6'b1001_10);
    dom_we = 1'b1; dom_waddr = 2'd1; dom_wdata = 8'h5a;
    step(); dom_we = 1'b0;
    chk_ctl("R2", 6'b1101_10);
    step(); chk_ctl("R2", 6'b1000_00);
    go_up("R3");
    step();
    read_chk("R7", 1, model[1]);

    // R8: request reversal mid-sequence completes down first
    pwr_req = 1'b0;
    step(); chk_ctl("R8", 6'b1001_10);
    pwr_req = 1'b1;
    step(); chk_ctl("R8", 6'b1101_10);
    step(); chk_ctl("R8", 6'b1000_00);
    step(); chk_ctl("R8", 6'b1001_11);
    step(); chk_ctl("R8", 6'b1011_11);
    step(); chk_ctl("R8", 6'b1001_11);
    step(); chk_ctl("R8", 6'b0001_01);
    step();
    for (int i = 0; i < NREG; i++) read_chk("R8", i, model[i]);

    // R8: reversal during power-up completes up, then goes down
    go_down("R2");
    pwr_req = 1'b1;
    step(); chk_ctl("R8", 6'b1001_11);
    pwr_req = 1'b0;
    step(); chk_ctl("R8", 6'b1011_11);
    step(); chk_ctl("R8", 6'b1001_11);
    step(); chk_ctl("R8", 6'b0001_01);
    step(); chk_ctl("R8", 6'b1001_10);
    step(); chk_ctl("R8", 6'b1101_10);
    step(); chk_ctl("R8", 6'b1000_00);
    go_up("R3");
    step();
    read_chk("R6", 3, model[3]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule